// File: doc/BRIEF.md
# Oldest-First Multi-Port Reservation Station

This block is the waiting room between in-order allocation and out-of-order execution. It holds up to twenty renamed micro-operations. Each entry keeps an opcode, a target execution port, a destination physical tag, a branch-prediction field, and two sources. Each source has a physical tag, a valid bit and a data word. Allocation takes a group of up to three micro-ops in one cycle. The whole group enters, or none of it does. Two writeback buses broadcast a destination tag together with its data. Every waiting source whose tag matches a broadcast captures that data.

An entry becomes ready once both of its sources are valid. Each cycle, every one of the five execution ports receives at most one ready micro-op. That micro-op is the oldest ready entry bound to the port, where age is the allocation order, not the slot number. A dispatched entry is released at the end of its dispatch cycle. A flush input empties the whole buffer in one cycle.

Top module: `uop_rs`

## Requirements
- R1: After reset the buffer is empty. All `dsp_vld` bits are 0, and `alloc_ready` is 1 even with all three bits of `alloc_lane` set.
- R2: `alloc_ready` is 1 exactly when the free entries number at least the count of set bits in `alloc_lane`. When `alloc_req` is 1 and `alloc_ready` is 0, no lane is written.
- R3: The buffer holds exactly 20 micro-ops. After 20 have been accepted and none has dispatched, `alloc_ready` is 0 for a single-lane request.
- R4: An accepted micro-op whose two sources are already valid appears on `dsp_*[p]` in the cycle after the accepting clock edge, where p is its 3-bit `alloc_port` value (0 to 4). It carries its opcode, its destination tag, its branch field, and source 0 and source 1 data.
- R5: Consider a waiting source whose tag equals `wb_tag[b]` while `wb_vld[b]` is 1. It takes `wb_data[b]` and becomes valid at that clock edge. When both buses carry the same tag, bus 0 wins. An entry with only one valid source does not dispatch.
- R6: A source that arrives invalid in the allocation cycle also captures a broadcast with a matching tag in that same cycle.
- R7: Each port dispatches at most one micro-op per cycle. Ready micro-ops bound to different ports dispatch in the same cycle.
- R8: Among ready entries bound to one port, the one allocated earliest dispatches first. Within a group, lane 0 is older than lane 1, and lane 1 is older than lane 2. The slot position of an entry has no effect on this order.
- R9: A dispatched entry is released at the end of its dispatch cycle. It never dispatches again, and the buffer occupancy drops by the number of dispatches.
- R10: With `flush` at 1, all `dsp_vld` bits are 0 in that cycle. All entries are cleared at the edge, and an allocation requested in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all entries |
| alloc_req | input | 1 | Allocate the lanes selected by alloc_lane |
| alloc_lane | input | 3 | Lanes present in the group |
| alloc_opc | input | 3x8 | Opcode per lane |
| alloc_port | input | 3x3 | Target port per lane (0..4) |
| alloc_dst | input | 3x6 | Destination physical tag per lane |
| alloc_bpred | input | 3x2 | Branch-prediction field per lane |
| alloc_src_tag | input | 3x2x6 | Source physical tags per lane |
| alloc_src_rdy | input | 3x2 | Source already valid per lane |
| alloc_src_data | input | 3x2x16 | Source data per lane |
| alloc_ready | output | 1 | Enough free entries for the selected lanes |
| wb_vld | input | 2 | Writeback bus valid |
| wb_tag | input | 2x6 | Writeback destination tag |
| wb_data | input | 2x16 | Writeback data |
| dsp_vld | output | 5 | Dispatch valid per port |
| dsp_opc | output | 5x8 | Dispatched opcode per port |
| dsp_dst | output | 5x6 | Dispatched destination tag per port |
| dsp_bpred | output | 5x2 | Dispatched branch field per port |
| dsp_src_data | output | 5x2x16 | Dispatched source data per port |

## Verification
Every result has a fixed latency:
- A ready allocation is on its dispatch port one cycle after the accepting edge.
- A broadcast makes its waiting entry dispatchable one cycle after the broadcast edge.
- An entry is gone one cycle after it dispatches.
- `alloc_ready` and the flush gating of `dsp_vld` act within the same cycle.

The bench drives every input just after a falling edge. It samples one falling edge later for the one-cycle results, and shortly after the input change for the same-cycle ones. Every expected dispatch order is derived from the allocation order the bench itself produced.

// File: rtl/uop_rs_pkg.sv
package uop_rs_pkg;
    parameter int RS_ENTRIES = 20;
    parameter int RS_PORTS   = 5;
    parameter int RS_LANES   = 3;
    parameter int RS_WB      = 2;

    typedef enum logic [1:0] {
        SRC_A = 2'd0,
        SRC_B = 2'd1
    } src_sel_e;

    localparam int RS_SRCS = 2;
endpackage

// File: rtl/uop_rs_slot_pick.sv
module uop_rs_slot_pick #(
    parameter int ENTRIES = 20,
    parameter int LANES   = 3,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]          busy,
    input  logic [LANES-1:0]            lane_req,
    output logic [LANES-1:0][IDX_W-1:0] lane_slot,
    output logic                        fits
);
    always_comb begin
        fits = (ENTRIES - $countones(busy)) >= $countones(lane_req);
        for (int k = 0; k < LANES; k++) begin
            int rank;
            int seen;
            logic found;
            rank  = 0;
            seen  = 0;
            found = 1'b0;
            lane_slot[k] = '0;
            for (int j = 0; j < k; j++) begin
                if (lane_req[j]) rank = rank + 1;
            end
            for (int i = 0; i < ENTRIES; i++) begin
                if (!busy[i]) begin
                    if (seen == rank && !found) begin
                        lane_slot[k] = IDX_W'(i);
                        found = 1'b1;
                    end
                    seen = seen + 1;
                end
            end
        end
    end
endmodule

// File: rtl/uop_rs_age_pick.sv
module uop_rs_age_pick #(
    parameter int ENTRIES = 20,
    parameter int SEQ_W   = 16
) (
    input  logic [ENTRIES-1:0]            req,
    input  logic [ENTRIES-1:0][SEQ_W-1:0] seq,
    input  logic [SEQ_W-1:0]              head,
    output logic [ENTRIES-1:0]            gnt,
    output logic                          any
);
    always_comb begin
        logic [SEQ_W-1:0] best_age;
        logic [SEQ_W-1:0] age;
        gnt      = '0;
        any      = 1'b0;
        best_age = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            age = head - seq[i];
            if (req[i] && (!any || age > best_age)) begin
                gnt      = '0;
                gnt[i]   = 1'b1;
                any      = 1'b1;
                best_age = age;
            end
        end
    end
endmodule

// File: rtl/uop_rs.sv
module uop_rs
    import uop_rs_pkg::*;
#(
    parameter int ENTRIES = RS_ENTRIES,
    parameter int PORTS   = RS_PORTS,
    parameter int LANES   = RS_LANES,
    parameter int WB      = RS_WB,
    parameter int TAG_W   = 6,
    parameter int DATA_W  = 16,
    parameter int OPC_W   = 8,
    parameter int BP_W    = 2,
    parameter int SEQ_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PORT_W = $clog2(PORTS)
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    flush,
    input  logic                                    alloc_req,
    input  logic [LANES-1:0]                        alloc_lane,
    input  logic [LANES-1:0][OPC_W-1:0]             alloc_opc,
    input  logic [LANES-1:0][PORT_W-1:0]            alloc_port,
    input  logic [LANES-1:0][TAG_W-1:0]             alloc_dst,
    input  logic [LANES-1:0][BP_W-1:0]              alloc_bpred,
    input  logic [LANES-1:0][RS_SRCS-1:0][TAG_W-1:0]  alloc_src_tag,
    input  logic [LANES-1:0][RS_SRCS-1:0]             alloc_src_rdy,
    input  logic [LANES-1:0][RS_SRCS-1:0][DATA_W-1:0] alloc_src_data,
    output logic                                    alloc_ready,
    input  logic [WB-1:0]                           wb_vld,
    input  logic [WB-1:0][TAG_W-1:0]                wb_tag,
    input  logic [WB-1:0][DATA_W-1:0]               wb_data,
    output logic [PORTS-1:0]                        dsp_vld,
    output logic [PORTS-1:0][OPC_W-1:0]             dsp_opc,
    output logic [PORTS-1:0][TAG_W-1:0]             dsp_dst,
    output logic [PORTS-1:0][BP_W-1:0]              dsp_bpred,
    output logic [PORTS-1:0][RS_SRCS-1:0][DATA_W-1:0] dsp_src_data
);
    typedef struct packed {
        logic                              vld;
        logic [OPC_W-1:0]                  opc;
        logic [PORT_W-1:0]                 port;
        logic [TAG_W-1:0]                  dst;
        logic [BP_W-1:0]                   bp;
        logic [RS_SRCS-1:0]                src_ok;
        logic [RS_SRCS-1:0][TAG_W-1:0]     src_tag;
        logic [RS_SRCS-1:0][DATA_W-1:0]    src_data;
        logic [SEQ_W-1:0]                  seq;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
        logic [SEQ_W-1:0]   head;
    } st_t;

    st_t st_q, st_d;

    logic [ENTRIES-1:0]                busy;
    logic [ENTRIES-1:0]                disp_mask;
    logic [ENTRIES-1:0][SEQ_W-1:0]     seq_vec;
    logic [PORTS-1:0][ENTRIES-1:0]     req_vec;
    logic [PORTS-1:0][ENTRIES-1:0]     gnt;
    logic [PORTS-1:0]                  gnt_any;
    logic [LANES-1:0][IDX_W-1:0]       lane_slot;
    logic                              fits;
    logic                              accept;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            busy[i]    = st_q.ent[i].vld;
            seq_vec[i] = st_q.ent[i].seq;
        end
    end

    uop_rs_slot_pick #(.ENTRIES(ENTRIES), .LANES(LANES)) u_slot (
        .busy      (busy),
        .lane_req  (alloc_lane),
        .lane_slot (lane_slot),
        .fits      (fits)
    );

    assign alloc_ready = fits;
    assign accept      = alloc_req & fits & ~flush;

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        always_comb begin
            for (int i = 0; i < ENTRIES; i++) begin
                req_vec[p][i] = st_q.ent[i].vld && (&st_q.ent[i].src_ok) &&
                                (st_q.ent[i].port == PORT_W'(p));
            end
        end

        uop_rs_age_pick #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W)) u_age (
            .req  (req_vec[p]),
            .seq  (seq_vec),
            .head (st_q.head),
            .gnt  (gnt[p]),
            .any  (gnt_any[p])
        );
    end

    always_comb begin
        disp_mask    = '0;
        dsp_vld      = '0;
        dsp_opc      = '0;
        dsp_dst      = '0;
        dsp_bpred    = '0;
        dsp_src_data = '0;
        for (int p = 0; p < PORTS; p++) begin
            dsp_vld[p] = gnt_any[p] & ~flush;
            for (int i = 0; i < ENTRIES; i++) begin
                if (gnt[p][i]) begin
                    dsp_opc[p]      = st_q.ent[i].opc;
                    dsp_dst[p]      = st_q.ent[i].dst;
                    dsp_bpred[p]    = st_q.ent[i].bp;
                    dsp_src_data[p] = st_q.ent[i].src_data;
                    disp_mask[i]    = ~flush;
                end
            end
        end
    end

    always_comb begin
        ent_t             nxt;
        logic [SEQ_W-1:0] rk;
        st_d = st_q;
        nxt  = '0;
        rk   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (disp_mask[i]) st_d.ent[i].vld = 1'b0;
            for (int s = 0; s < RS_SRCS; s++) begin
                if (!st_q.ent[i].src_ok[s]) begin
                    for (int b = WB - 1; b >= 0; b--) begin
                        if (wb_vld[b] && wb_tag[b] == st_q.ent[i].src_tag[s]) begin
                            st_d.ent[i].src_ok[s]   = 1'b1;
                            st_d.ent[i].src_data[s] = wb_data[b];
                        end
                    end
                end
            end
        end
        if (accept) begin
            for (int k = 0; k < LANES; k++) begin
                if (alloc_lane[k]) begin
                    nxt.vld      = 1'b1;
                    nxt.opc      = alloc_opc[k];
                    nxt.port     = alloc_port[k];
                    nxt.dst      = alloc_dst[k];
                    nxt.bp       = alloc_bpred[k];
                    nxt.src_ok   = alloc_src_rdy[k];
                    nxt.src_tag  = alloc_src_tag[k];
                    nxt.src_data = alloc_src_data[k];
                    nxt.seq      = st_q.head + rk;
                    for (int s = 0; s < RS_SRCS; s++) begin
                        if (!alloc_src_rdy[k][s]) begin
                            for (int b = WB - 1; b >= 0; b--) begin
                                if (wb_vld[b] && wb_tag[b] == alloc_src_tag[k][s]) begin
                                    nxt.src_ok[s]   = 1'b1;
                                    nxt.src_data[s] = wb_data[b];
                                end
                            end
                        end
                    end
                    st_d.ent[lane_slot[k]] = nxt;
                    rk = rk + 1'b1;
                end
            end
            st_d.head = st_q.head + rk;
        end
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) st_d.ent[i].vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/uop_rs_chk.sv
module uop_rs_chk #(
    parameter int ENTRIES = 20,
    parameter int PORTS   = 5,
    parameter int LANES   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               alloc_req,
    input logic [LANES-1:0]   alloc_lane,
    input logic               alloc_ready,
    input logic [PORTS-1:0]   dsp_vld,
    input logic [ENTRIES-1:0] busy,
    input logic [ENTRIES-1:0] disp_mask
);
    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (busy == '0));

    // R10
    flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (dsp_vld == '0));

    // R2
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !alloc_ready && !flush) |=>
        ($countones(busy) <= $past($countones(busy))));

    // R9
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && alloc_ready && !flush) |=>
        ($countones(busy) == $past($countones(busy)) - $past($countones(dsp_vld))
                             + $past($countones(alloc_lane))));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|disp_mask) |=> ((busy & $past(disp_mask)) == '0));

    // R7
    one_per_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(disp_mask) == $countones(dsp_vld));
endmodule

bind uop_rs uop_rs_chk #(.ENTRIES(ENTRIES), .PORTS(PORTS), .LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .alloc_req   (alloc_req),
    .alloc_lane  (alloc_lane),
    .alloc_ready (alloc_ready),
    .dsp_vld     (dsp_vld),
    .busy        (busy),
    .disp_mask   (disp_mask)
);

// File: tb/uop_rs_tb.sv
`timescale 1ns/1ps
module uop_rs_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush;
    logic alloc_req;
    logic [2:0] alloc_lane;
    logic [2:0][7:0] alloc_opc;
    logic [2:0][2:0] alloc_port;
    logic [2:0][5:0] alloc_dst;
    logic [2:0][1:0] alloc_bpred;
    logic [2:0][1:0][5:0] alloc_src_tag;
    logic [2:0][1:0] alloc_src_rdy;
    logic [2:0][1:0][15:0] alloc_src_data;
    logic alloc_ready;
    logic [1:0] wb_vld;
    logic [1:0][5:0] wb_tag;
    logic [1:0][15:0] wb_data;
    logic [4:0] dsp_vld;
    logic [4:0][7:0] dsp_opc;
    logic [4:0][5:0] dsp_dst;
    logic [4:0][1:0] dsp_bpred;
    logic [4:0][1:0][15:0] dsp_src_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uop_rs u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_req(alloc_req), .alloc_lane(alloc_lane), .alloc_opc(alloc_opc),
        .alloc_port(alloc_port), .alloc_dst(alloc_dst), .alloc_bpred(alloc_bpred),
        .alloc_src_tag(alloc_src_tag), .alloc_src_rdy(alloc_src_rdy),
        .alloc_src_data(alloc_src_data), .alloc_ready(alloc_ready),
        .wb_vld(wb_vld), .wb_tag(wb_tag), .wb_data(wb_data),
        .dsp_vld(dsp_vld), .dsp_opc(dsp_opc), .dsp_dst(dsp_dst),
        .dsp_bpred(dsp_bpred), .dsp_src_data(dsp_src_data)
    );

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic clr_in();
        flush = 1'b0; alloc_req = 1'b0; alloc_lane = '0; wb_vld = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_lane(int k, logic [7:0] opc, int prt,
                            logic [5:0] t0, logic r0, logic [15:0] d0,
                            logic [5:0] t1, logic r1, logic [15:0] d1);
        alloc_lane[k]        = 1'b1;
        alloc_opc[k]         = opc;
        alloc_port[k]        = 3'(prt);
        alloc_dst[k]         = opc[5:0];
        alloc_bpred[k]       = opc[1:0];
        alloc_src_tag[k][0]  = t0; alloc_src_rdy[k][0] = r0; alloc_src_data[k][0] = d0;
        alloc_src_tag[k][1]  = t1; alloc_src_rdy[k][1] = r1; alloc_src_data[k][1] = d1;
    endtask

    task automatic fire();
        alloc_req = 1'b1;
        step();
        clr_in();
    endtask

    task automatic wb_set(int b, logic [5:0] tag, logic [15:0] data);
        wb_vld[b] = 1'b1; wb_tag[b] = tag; wb_data[b] = data;
    endtask

    initial begin
        alloc_opc = '0; alloc_port = '0; alloc_dst = '0; alloc_bpred = '0;
        alloc_src_tag = '0; alloc_src_rdy = '0; alloc_src_data = '0;
        wb_tag = '0; wb_data = '0;
        clr_in();
        repeat (4) step();
        rst_n = 1'b1;
        alloc_lane = 3'b111;
        #1;
        chk("R1 reset dsp_vld", 64'(dsp_vld), 64'h0);
        chk("R1 reset alloc_ready", 64'(alloc_ready), 64'h1);
        clr_in();
        step();

        // R4 R8 R9: sweep every port and group size with ready operands
        for (int p = 0; p < 5; p++) begin
            for (int n = 1; n <= 3; n++) begin
                for (int k = 0; k < n; k++) begin
                    logic [7:0] o;
                    o = 8'(p * 16 + n * 4 + k);
                    set_lane(k, o, p, 6'd1, 1'b1, {o, 8'hA5}, 6'd2, 1'b1, {8'h5A, o});
                end
                fire();
                for (int k = 0; k < n; k++) begin
                    logic [7:0] o;
                    o = 8'(p * 16 + n * 4 + k);
                    chk("R4 sweep dsp_vld", 64'(dsp_vld), 64'(5'b1 << p));
                    chk("R8 sweep opc order", 64'(dsp_opc[p]), 64'(o));
                    chk("R4 sweep dst", 64'(dsp_dst[p]), 64'(o[5:0]));
                    chk("R4 sweep bpred", 64'(dsp_bpred[p]), 64'(o[1:0]));
                    chk("R4 sweep src0", 64'(dsp_src_data[p][0]), 64'({o, 8'hA5}));
                    chk("R4 sweep src1", 64'(dsp_src_data[p][1]), 64'({8'h5A, o}));
                    step();
                end
                chk("R9 sweep released", 64'(dsp_vld), 64'h0);
            end
        end

        // R7: five ports in parallel after one broadcast
        for (int k = 0; k < 3; k++) set_lane(k, 8'(8'h30 + k), k, 6'd20, 1'b0, 16'h0, 6'd0, 1'b1, 16'h0);
        fire();
        for (int k = 0; k < 2; k++) set_lane(k, 8'(8'h33 + k), k + 3, 6'd20, 1'b0, 16'h0, 6'd0, 1'b1, 16'h0);
        fire();
        chk("R5 waiting not dispatched", 64'(dsp_vld), 64'h0);
        wb_set(1, 6'd20, 16'hBEEF);
        step();
        clr_in();
        chk("R7 all ports same cycle", 64'(dsp_vld), 64'h1F);
        for (int p = 0; p < 5; p++) chk("R5 bus1 capture", 64'(dsp_src_data[p][0]), 64'hBEEF);
        step();
        chk("R9 parallel released", 64'(dsp_vld), 64'h0);

        // R5: one source at a time, then bus priority
        set_lane(0, 8'h40, 2, 6'd30, 1'b0, 16'h0, 6'd31, 1'b0, 16'h0);
        fire();
        wb_set(0, 6'd30, 16'hAAAA);
        step(); clr_in();
        chk("R5 half ready stays", 64'(dsp_vld), 64'h0);
        wb_set(1, 6'd31, 16'hBBBB);
        step(); clr_in();
        chk("R5 both ready dispatch", 64'(dsp_vld), 64'h04);
        chk("R5 src0 data", 64'(dsp_src_data[2][0]), 64'hAAAA);
        chk("R5 src1 data", 64'(dsp_src_data[2][1]), 64'hBBBB);
        step();
        set_lane(0, 8'h41, 1, 6'd33, 1'b0, 16'h0, 6'd0, 1'b1, 16'h7777);
        fire();
        wb_set(0, 6'd33, 16'h1111);
        wb_set(1, 6'd33, 16'h2222);
        step(); clr_in();
        chk("R5 bus0 priority vld", 64'(dsp_vld), 64'h02);
        chk("R5 bus0 priority data", 64'(dsp_src_data[1][0]), 64'h1111);
        step();

        // R6: capture during the allocation cycle
        set_lane(0, 8'h42, 3, 6'd40, 1'b0, 16'h0, 6'd0, 1'b1, 16'h0);
        wb_set(0, 6'd40, 16'h4444);
        fire();
        chk("R6 same-cycle capture vld", 64'(dsp_vld), 64'h08);
        chk("R6 same-cycle capture data", 64'(dsp_src_data[3][0]), 64'h4444);
        step();

        // R8: a younger micro-op in a lower slot still waits its turn
        set_lane(0, 8'h51, 1, 6'd0, 1'b1, 16'h0, 6'd0, 1'b1, 16'h0);
        set_lane(1, 8'h52, 4, 6'd7, 1'b0, 16'h0, 6'd0, 1'b1, 16'h0);
        set_lane(2, 8'h53, 4, 6'd7, 1'b0, 16'h0, 6'd0, 1'b1, 16'h0);
        fire();
        chk("R4 first group port1", 64'(dsp_opc[1]), 64'h51);
        step();
        set_lane(0, 8'h54, 4, 6'd7, 1'b0, 16'h0, 6'd0, 1'b1, 16'h0);
        fire();
        wb_set(1, 6'd7, 16'h0707);
        step(); clr_in();
        chk("R8 age order 1", 64'(dsp_opc[4]), 64'h52);
        step();
        chk("R8 age order 2", 64'(dsp_opc[4]), 64'h53);
        step();
        chk("R8 age order 3", 64'(dsp_opc[4]), 64'h54);
        chk("R8 age order 3 vld", 64'(dsp_vld), 64'h10);
        step();
        chk("R9 age test released", 64'(dsp_vld), 64'h0);

        // R2 R3: fill to the limit, refused group, strict order
        for (int g = 0; g < 6; g++) begin
            for (int k = 0; k < 3; k++)
                set_lane(k, 8'(8'h80 + g * 3 + k), 2, 6'd9, 1'b0, 16'h0, 6'd0, 1'b1, 16'h0);
            fire();
        end
        alloc_lane = 3'b111; #1;
        chk("R2 three lanes refused at 18", 64'(alloc_ready), 64'h0);
        alloc_lane = 3'b011; #1;
        chk("R2 two lanes fit at 18", 64'(alloc_ready), 64'h1);
        clr_in();
        for (int k = 0; k < 3; k++)
            set_lane(k, 8'(8'hF0 + k), 2, 6'd0, 1'b1, 16'h0, 6'd0, 1'b1, 16'h0);
        fire();
        chk("R2 refused group not dispatched", 64'(dsp_vld), 64'h0);
        for (int k = 0; k < 2; k++)
            set_lane(k, 8'(8'h92 + k), 2, 6'd9, 1'b0, 16'h0, 6'd0, 1'b1, 16'h0);
        fire();
        alloc_lane = 3'b001; #1;
        chk("R3 full at 20", 64'(alloc_ready), 64'h0);
        clr_in();
        wb_set(0, 6'd9, 16'h0909);
        step(); clr_in();
        for (int i = 0; i < 20; i++) begin
            chk("R8 full drain vld", 64'(dsp_vld), 64'h04);
            chk("R8 full drain order", 64'(dsp_opc[2]), 64'(8'h80 + i));
            step();
        end
        chk("R2 nothing extra stored", 64'(dsp_vld), 64'h0);

        // R10: flush clears, drops allocation, gates dispatch
        for (int k = 0; k < 3; k++) set_lane(k, 8'(8'hC0 + k), 0, 6'd11, 1'b0, 16'h0, 6'd0, 1'b1, 16'h0);
        fire();
        for (int k = 0; k < 3; k++) set_lane(k, 8'(8'hC4 + k), 1, 6'd0, 1'b1, 16'h0, 6'd0, 1'b1, 16'h0);
        alloc_req = 1'b1;
        flush = 1'b1;
        wb_set(0, 6'd11, 16'h1111);
        step(); clr_in();
        chk("R10 flush drops alloc", 64'(dsp_vld), 64'h0);
        alloc_lane = 3'b111; #1;
        chk("R10 flush empties", 64'(alloc_ready), 64'h1);
        clr_in();
        wb_set(1, 6'd11, 16'h2222);
        step(); clr_in();
        chk("R10 flushed never wakes", 64'(dsp_vld), 64'h0);
        set_lane(0, 8'hD0, 3, 6'd0, 1'b1, 16'h0, 6'd0, 1'b1, 16'h0);
        fire();
        flush = 1'b1; #1;
        chk("R10 dispatch gated in flush cycle", 64'(dsp_vld), 64'h0);
        step(); clr_in();
        chk("R10 gated entry gone", 64'(dsp_vld), 64'h0);
        set_lane(0, 8'hD1, 3, 6'd0, 1'b1, 16'h0, 6'd0, 1'b1, 16'h0);
        fire();
        chk("R4 after flush dispatch", 64'(dsp_vld), 64'h08);
        chk("R4 after flush opc", 64'(dsp_opc[3]), 64'hD1);
        step();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule